// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This unit compares two IEEE-754 operands, both in single or both in double precision, and evaluates one of sixteen compare predicates on them. Each operand is sorted into one of five classes: zero, finite non-zero, infinity, quiet NaN or signaling NaN. From those classes and the operand bits the unit derives three relations: unordered, equal and less. The 4-bit predicate code picks which relations make the result true. Its top bit chooses the signaling form of the predicate, which also reports quiet NaNs as invalid.

The boolean result is stored in one of eight condition flags, chosen by a 3-bit index. The other seven flags keep their values. A one-cycle invalid-operation pulse goes with each compare that meets a signaling NaN, or that meets a quiet NaN under a signaling predicate. A pipeline issues a compare by raising the valid strobe for one cycle with the operands, format, code and flag index. Later conditional moves or branches read the flag vector.

Top module: `fpcmp_unit`

## Requirements
- R1: After a synchronous active-low reset, all eight flags read 0 and the invalid pulse is low.
- R2: When the valid strobe is high at a clock edge, the flag at the given index takes the compare result, visible after that edge. The other seven flags keep their values.
- R3: While the valid strobe is low, the flag vector holds its value and the invalid pulse stays low, whatever the other inputs do.
- R4: An all-ones exponent with a zero fraction is an infinity. An all-ones exponent with a non-zero fraction is a NaN. The NaN is quiet when the fraction MSB is 1 and signaling when it is 0. A pair is unordered when either operand is a NaN.
- R5: Positive zero and negative zero compare equal. Two non-NaN operands with identical bits compare equal. A NaN is never equal to anything.
- R6: Less follows signed numeric order, and infinities are the extremes. Zeros of either sign are never less than one another. Less is false whenever the pair is unordered.
- R7: The result is (code bit 0 AND unordered) OR (code bit 1 AND equal) OR (code bit 2 AND less). Codes whose low three bits are 000 always give false.
- R8: With the format input at 0 (single), only bits 31:0 of each operand are compared and bits 63:32 have no effect. With the format input at 1 (double), all 64 bits are compared.
- R9: When code bit 3 is 1 and either operand is a quiet NaN, the invalid pulse is raised.
- R10: A signaling NaN in either operand raises the invalid pulse for every code.
- R11: The invalid pulse is high for exactly the one cycle after the strobed compare. With code bit 3 at 0 and no signaling NaN, it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_valid | input | 1 | Strobe: perform one compare this cycle |
| fmt_double | input | 1 | 0 = single precision in bits 31:0, 1 = double precision |
| pred_code | input | 4 | Predicate code; bit 3 selects the signaling form |
| flag_sel | input | 3 | Index of the flag that receives the result |
| op_a | input | 64 | First operand (left side of the relation) |
| op_b | input | 64 | Second operand |
| cc_flags | output | 8 | Condition flag vector |
| invalid_exc | output | 1 | Invalid-operation pulse |

## Verification
Both results are due one rising edge after the strobe. The selected flag and the invalid pulse are each registered once, so they are visible right after the edge that samples the valid strobe. The bench changes inputs on the falling edge, and it lets exactly one rising edge pass with the strobe high. It then compares the full flag vector and the pulse on the next falling edge against a running model of all eight flags. To confirm that the pulse lasts a single cycle and that an idle strobe leaves the state unchanged, the bench samples again one or more falling edges later with the strobe low.

// File: rtl/fpcmp_pkg.sv
// Package: shared types for the floating-point compare predicate unit.
// Assumes operands are at most double precision (64 bits).
package fpcmp_pkg;

    localparam int OPER_W = 64;
    localparam int MAG_W  = OPER_W - 1;

    // Operand classes recognised by the decoder
    typedef enum logic [2:0] {
        CLS_ZERO   = 3'd0,
        CLS_FINITE = 3'd1,
        CLS_INF    = 3'd2,
        CLS_QNAN   = 3'd3,
        CLS_SNAN   = 3'd4
    } fp_class_e;

    // Decoded operand, magnitude right-aligned and zero-extended
    typedef struct packed {
        logic              sign;
        logic [MAG_W-1:0]  mag;
        fp_class_e         cls;
    } fp_oper_t;

endpackage

// File: rtl/fp_field_decode.sv
// Module: fp_field_decode
// Splits one IEEE-754 word of a given exponent/fraction width into sign,
// magnitude and class. Subnormals are classed as finite non-zero.
// Assumes the fraction MSB marks a quiet NaN.
module fp_field_decode
    import fpcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word,
    output logic              sign,
    output logic [WORD_W-2:0] mag,
    output fp_class_e         cls
);

    logic exp_ones;
    logic exp_zero;
    logic frac_zero;
    logic quiet_bit;

    assign sign      = word[WORD_W-1];
    assign mag       = word[WORD_W-2:0];
    assign exp_ones  = &word[WORD_W-2:FRAC_W];
    assign exp_zero  = ~|word[WORD_W-2:FRAC_W];
    assign frac_zero = ~|word[FRAC_W-1:0];
    assign quiet_bit = word[FRAC_W-1];

    // Class selection from exponent and fraction fields
    always_comb begin
        if (exp_ones && frac_zero)      cls = CLS_INF;
        else if (exp_ones && quiet_bit) cls = CLS_QNAN;
        else if (exp_ones)              cls = CLS_SNAN;
        else if (exp_zero && frac_zero) cls = CLS_ZERO;
        else                            cls = CLS_FINITE;
    end

endmodule

// File: rtl/fp_classify.sv
// Module: fp_classify
// Decodes one operand in either single (bits 31:0) or double format and
// returns a format-independent descriptor. Upper bits are ignored in single.
module fp_classify
    import fpcmp_pkg::*;
(
    input  logic              fmt_double,
    input  logic [OPER_W-1:0] operand,
    output fp_oper_t          info
);

    localparam int SGL_EXP = 8;
    localparam int SGL_FRC = 23;
    localparam int DBL_EXP = 11;
    localparam int DBL_FRC = 52;
    localparam int SGL_W   = 1 + SGL_EXP + SGL_FRC;

    logic               s_sign;
    logic [SGL_W-2:0]   s_mag;
    fp_class_e          s_cls;
    logic               d_sign;
    logic [MAG_W-1:0]   d_mag;
    fp_class_e          d_cls;

    fp_field_decode #(.EXP_W(SGL_EXP), .FRAC_W(SGL_FRC)) u_sgl (
        .word (operand[SGL_W-1:0]),
        .sign (s_sign),
        .mag  (s_mag),
        .cls  (s_cls)
    );

    fp_field_decode #(.EXP_W(DBL_EXP), .FRAC_W(DBL_FRC)) u_dbl (
        .word (operand),
        .sign (d_sign),
        .mag  (d_mag),
        .cls  (d_cls)
    );

    // Format multiplexer onto the common descriptor
    always_comb begin
        if (fmt_double) begin
            info.sign = d_sign;
            info.mag  = d_mag;
            info.cls  = d_cls;
        end else begin
            info.sign = s_sign;
            info.mag  = {{(MAG_W-SGL_W+1){1'b0}}, s_mag};
            info.cls  = s_cls;
        end
    end

endmodule

// File: rtl/fp_relation.sv
// Module: fp_relation
// Derives unordered, equal and a-less-than-b from two decoded operands.
// Assumes both descriptors come from the same format.
module fp_relation
    import fpcmp_pkg::*;
(
    input  fp_oper_t opa,
    input  fp_oper_t opb,
    output logic     unordered,
    output logic     equal,
    output logic     less
);

    logic nan_a;
    logic nan_b;
    logic both_zero;
    logic mag_lt;
    logic mag_gt;

    assign nan_a     = (opa.cls == CLS_QNAN) || (opa.cls == CLS_SNAN);
    assign nan_b     = (opb.cls == CLS_QNAN) || (opb.cls == CLS_SNAN);
    assign both_zero = (opa.cls == CLS_ZERO) && (opb.cls == CLS_ZERO);
    assign mag_lt    = opa.mag < opb.mag;
    assign mag_gt    = opa.mag > opb.mag;

    // Relation bits; signed order via sign then magnitude
    always_comb begin
        unordered = nan_a || nan_b;
        equal     = !unordered &&
                    (both_zero || ((opa.sign == opb.sign) && (opa.mag == opb.mag)));
        if (unordered || both_zero)  less = 1'b0;
        else if (opa.sign != opb.sign) less = opa.sign;
        else if (opa.sign)           less = mag_gt;
        else                         less = mag_lt;
    end

    // Relations are mutually exclusive (R5, R6)
    always_comb begin
        assert_rel_exclusive_R6: assert (!(unordered && (equal || less)) && !(equal && less))
            else $error("relation bits overlap");
    end

endmodule

// File: rtl/fp_predicate.sv
// Module: fp_predicate
// Applies the 4-bit predicate code to the relation bits and decides the
// invalid-operation condition. Purely combinational.
module fp_predicate (
    input  logic [3:0] pred_code,
    input  logic       unordered,
    input  logic       equal,
    input  logic       less,
    input  logic       any_qnan,
    input  logic       any_snan,
    output logic       result,
    output logic       invalid
);

    // Predicate evaluation and exception decision
    always_comb begin
        result  = (pred_code[0] && unordered) ||
                  (pred_code[1] && equal) ||
                  (pred_code[2] && less);
        invalid = any_snan || (pred_code[3] && any_qnan);
    end

    // Codes with no relation bit selected never yield true (R7)
    always_comb begin
        assert_false_code_R7: assert (!((pred_code[2:0] == 3'b000) && result))
            else $error("false predicate produced true");
    end

endmodule

// File: rtl/fpcmp_unit.sv
// Module: fpcmp_unit (top)
// Compares two floating-point operands under a predicate code and stores the
// result in one of FLAG_COUNT condition flags; pulses invalid_exc for NaN traps.
// Assumes one compare per strobe; results appear one edge after the strobe.
module fpcmp_unit
    import fpcmp_pkg::*;
#(
    parameter int FLAG_COUNT = 8,
    localparam int SEL_W     = $clog2(FLAG_COUNT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmp_valid,
    input  logic                  fmt_double,
    input  logic [3:0]            pred_code,
    input  logic [SEL_W-1:0]      flag_sel,
    input  logic [OPER_W-1:0]     op_a,
    input  logic [OPER_W-1:0]     op_b,
    output logic [FLAG_COUNT-1:0] cc_flags,
    output logic                  invalid_exc
);

    localparam int N_OPS = 2;

    logic [OPER_W-1:0]     op_in [N_OPS];
    fp_oper_t              op_info [N_OPS];
    logic [N_OPS-1:0]      is_qnan;
    logic [N_OPS-1:0]      is_snan;
    logic                  rel_un;
    logic                  rel_eq;
    logic                  rel_lt;
    logic                  pred_true;
    logic                  pred_inv;
    logic [FLAG_COUNT-1:0] sel_mask;

    assign op_in[0] = op_a;
    assign op_in[1] = op_b;

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_oper
        fp_classify u_cls (
            .fmt_double (fmt_double),
            .operand    (op_in[gi]),
            .info       (op_info[gi])
        );
        assign is_qnan[gi] = (op_info[gi].cls == CLS_QNAN);
        assign is_snan[gi] = (op_info[gi].cls == CLS_SNAN);
    end

    fp_relation u_rel (
        .opa       (op_info[0]),
        .opb       (op_info[1]),
        .unordered (rel_un),
        .equal     (rel_eq),
        .less      (rel_lt)
    );

    fp_predicate u_pred (
        .pred_code (pred_code),
        .unordered (rel_un),
        .equal     (rel_eq),
        .less      (rel_lt),
        .any_qnan  (|is_qnan),
        .any_snan  (|is_snan),
        .result    (pred_true),
        .invalid   (pred_inv)
    );

    assign sel_mask = {{(FLAG_COUNT-1){1'b0}}, 1'b1} << flag_sel;

    // Flag register: write the selected flag on a strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            cc_flags <= '0;
        else if (cmp_valid)
            cc_flags <= (cc_flags & ~sel_mask) | (pred_true ? sel_mask : '0);
    end

    // Invalid pulse: one cycle after a strobed compare that traps
    always_ff @(posedge clk) begin
        if (!rst_n)
            invalid_exc <= 1'b0;
        else
            invalid_exc <= cmp_valid && pred_inv;
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> $stable(cc_flags));

    assert_idle_no_exc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> !invalid_exc);

    assert_others_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> (((cc_flags ^ $past(cc_flags)) & ~$past(sel_mask)) == '0));

    assert_snan_traps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && (|is_snan)) |=> invalid_exc);

    assert_quiet_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !pred_code[3] && !(|is_snan)) |=> !invalid_exc);

    assert_signal_qnan_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && pred_code[3] && (|is_qnan)) |=> invalid_exc);

endmodule

// File: tb/sim_fpcmp_unit.sv
// Bench for fpcmp_unit: vector table walked by one loop, then directed tests.
module sim_fpcmp_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic        fmt_double = 1'b0;
    logic [3:0]  pred_code = 4'd0;
    logic [2:0]  flag_sel = 3'd0;
    logic [63:0] op_a = 64'd0;
    logic [63:0] op_b = 64'd0;
    logic [7:0]  cc_flags;
    logic        invalid_exc;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] model = 8'd0;

    always #10 clk = ~clk;

    fpcmp_unit u0 (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .fmt_double(fmt_double),
        .pred_code(pred_code), .flag_sel(flag_sel), .op_a(op_a), .op_b(op_b),
        .cc_flags(cc_flags), .invalid_exc(invalid_exc)
    );

    // Single-precision constants (upper 32 bits zero)
    localparam logic [63:0] S_ONE  = 64'h3F80_0000;
    localparam logic [63:0] S_TWO  = 64'h4000_0000;
    localparam logic [63:0] S_MONE = 64'hBF80_0000;
    localparam logic [63:0] S_PZ   = 64'h0000_0000;
    localparam logic [63:0] S_NZ   = 64'h8000_0000;
    localparam logic [63:0] S_NINF = 64'hFF80_0000;
    localparam logic [63:0] S_QNAN = 64'h7FC0_0000;
    localparam logic [63:0] S_SNAN = 64'h7F80_0001;
    // Double-precision constants
    localparam logic [63:0] D_ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] D_TWO  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] D_MTWO = 64'hC000_0000_0000_0000;
    localparam logic [63:0] D_PINF = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] D_QNAN = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] D_SNAN = 64'h7FF0_0000_0000_0001;
    localparam logic [63:0] D_NZ   = 64'h8000_0000_0000_0000;

    // Vector: {fmt, code[3:0], a[63:0], b[63:0], exp_result, exp_invalid}
    localparam int NV = 19;
    localparam logic [134:0] VECS [NV] = '{
        {1'b0, 4'b0010, S_ONE,  S_ONE,  1'b1, 1'b0},  // R5 equal values
        {1'b0, 4'b0100, S_ONE,  S_TWO,  1'b1, 1'b0},  // R6 1<2
        {1'b0, 4'b0100, S_TWO,  S_ONE,  1'b0, 1'b0},  // R6 2<1 false
        {1'b0, 4'b0010, S_PZ,   S_NZ,   1'b1, 1'b0},  // R5 +0 == -0
        {1'b0, 4'b0001, S_QNAN, S_ONE,  1'b1, 1'b0},  // R4 unordered
        {1'b0, 4'b0011, S_QNAN, S_QNAN, 1'b1, 1'b0},  // R7 ueq on NaNs
        {1'b0, 4'b1010, S_QNAN, S_ONE,  1'b0, 1'b1},  // R9 signaling eq
        {1'b0, 4'b0110, S_NINF, S_MONE, 1'b1, 1'b0},  // R6 -inf <= -1
        {1'b0, 4'b1100, S_MONE, S_NINF, 1'b0, 1'b0},  // R6 -1 < -inf false
        {1'b0, 4'b0000, S_SNAN, S_ONE,  1'b0, 1'b1},  // R10 snan, false code
        {1'b1, 4'b0100, D_MTWO, D_ONE,  1'b1, 1'b0},  // R6 double -2<1
        {1'b1, 4'b0110, D_TWO,  D_TWO,  1'b1, 1'b0},  // R7 ole equal
        {1'b1, 4'b1111, D_QNAN, D_TWO,  1'b1, 1'b1},  // R9 ngt with qnan
        {1'b1, 4'b0101, D_PINF, D_TWO,  1'b0, 1'b0},  // R6 +inf not less
        {1'b1, 4'b0010, D_SNAN, D_SNAN, 1'b0, 1'b1},  // R10 R5 snan never equal
        {1'b0, 4'b0010, 64'hDEAD_BEEF_3F80_0000,
                        64'h1234_5678_3F80_0000, 1'b1, 1'b0},  // R8 upper ignored
        {1'b1, 4'b0100, D_NZ,   64'd0,  1'b0, 1'b0},  // R6 -0 not less than +0
        {1'b0, 4'b0111, S_ONE,  S_TWO,  1'b1, 1'b0},  // R7 ule ordered less
        {1'b0, 4'b1011, S_ONE,  S_ONE,  1'b1, 1'b0}   // R11 signaling, no NaN
    };

    task automatic check(input string req, input logic [31:0] actual,
                         input logic [31:0] expected);
        n_tests++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    // Issue one strobed compare; outputs are sampled one falling edge later
    task automatic issue(input logic fmt, input logic [3:0] code, input logic [2:0] idx,
                         input logic [63:0] a, input logic [63:0] b);
        fmt_double = fmt; pred_code = code; flag_sel = idx;
        op_a = a; op_b = b; cmp_valid = 1'b1;
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check("R1 flags after reset", {24'd0, cc_flags}, 32'd0);
        check("R1 exc after reset", {31'd0, invalid_exc}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [134:0] v;
            v = VECS[i];
            issue(v[134], v[133:130], 3'(i % 8), v[129:66], v[65:2]);
            model[i % 8] = v[1];
            check($sformatf("R2/R7 vec %0d flags", i), {24'd0, cc_flags}, {24'd0, model});
            check($sformatf("R9/R10 vec %0d exc", i), {31'd0, invalid_exc}, {31'd0, v[0]});
        end

        // R11: pulse lasts one cycle after a trapping compare
        issue(1'b0, 4'b1000, 3'd5, S_QNAN, S_ONE);
        model[5] = 1'b0;
        check("R11 pulse high", {31'd0, invalid_exc}, 32'd1);
        @(negedge clk);
        check("R11 pulse dropped", {31'd0, invalid_exc}, 32'd0);

        // R3: idle strobe with changing inputs keeps flags
        fmt_double = 1'b0; pred_code = 4'b1111; flag_sel = 3'd0;
        op_a = S_SNAN; op_b = S_SNAN;
        repeat (3) @(negedge clk);
        check("R3 flags held", {24'd0, cc_flags}, {24'd0, model});
        check("R3 no exc when idle", {31'd0, invalid_exc}, 32'd0);

        // R2: set then clear one flag, neighbours untouched
        issue(1'b0, 4'b0010, 3'd3, S_ONE, S_ONE);
        model[3] = 1'b1;
        check("R2 set flag 3", {24'd0, cc_flags}, {24'd0, model});
        issue(1'b0, 4'b0100, 3'd3, S_TWO, S_ONE);
        model[3] = 1'b0;
        check("R2 clear flag 3", {24'd0, cc_flags}, {24'd0, model});

        // R8: double format sees the upper bits that single ignores
        issue(1'b1, 4'b0010, 3'd7, 64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_3F80_0000);
        model[7] = 1'b0;
        check("R8 double uses upper bits", {24'd0, cc_flags}, {24'd0, model});

        // R1: reset mid-run clears everything
        issue(1'b0, 4'b0010, 3'd6, S_ONE, S_ONE);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 flags cleared by reset", {24'd0, cc_flags}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule